// File: doc/BRIEF.md
# Slot-Mapped Priority Interrupt Controller

This block gathers interrupt request pulses from a parameterised set of on-chip sources and forwards the most urgent one to the processor core. The core sees this as a single request line at a programmable level out of eight. Three sources are special: a USB controller (source 0) and two serial channels (sources 1 and 2). None of the three has a position of its own. Each reaches the priority order only through one of four serial slots, and each slot has a 2-bit selector. All other sources (3 and up) have a fixed order by index.

A configuration register does several jobs. It fills the slots and chooses whether the slots sit together at the top of the order or are spread among the other sources. It can lift one source above all others. It also sets the request level and turns the request output on or off. Software sees pending, mask and in-service registers through a simple read/write port.

When the core acknowledges, the block latches the winning source's fixed vector. It then marks that source in service and clears its pending bit. If nothing is eligible at that moment, the block returns an error vector instead.

Top module: `prio_intc`

## Requirements
- R1: A one-cycle pulse on `src_req_i[i]` sets pending bit i. Writing a one to bit i of the pending register (address 1) clears it. If a set and a clear hit the same bit in the same cycle, the set wins.
- R2: Mask register (address 2): a bit of 1 enables that source, and it resets to 0. A pending source that is masked stays readable as pending but raises no request. It raises a request again as soon as it is unmasked.
- R3: Each slot selector is 2 bits: 00 = USB (source 0), 01 = serial channel 2 (source 1), 10 = serial channel 3 (source 2), 11 = slot empty. If a special source is named by no slot, it never requests. If it is named by several slots, it takes the highest-priority slot.
- R4: The vector of source i is i. This holds no matter which slot holds the source, the placement mode or the promotion.
- R5: Grouped mode: slots a, b, c and d take ranks 0 to 3, and generic source 3+k takes rank 4+k. Spread mode: slot s takes rank s*(GAP+1), and generic source 3+k takes rank k+1+min(k/GAP,3). Rank 0 is the most urgent.
- R6: The 5-bit promote field names a source that outranks every other source. A value of NSRC or more promotes nothing.
- R7: `irq_o` is registered. It is either all zero or has exactly the bit at the level field set. It is set only when the enable bit is 1 and an eligible source is not blocked.
- R8: On `iack_i`, the winner's vector appears on `vec_o` after the clock edge, and reading address 4 returns it. At the same edge the winner's in-service bit is set and its pending bit is cleared.
- R9: If `iack_i` arrives when no source is eligible, including one masked after it had raised a request, the error vector 31 is latched.
- R10: A source in service blocks requests of equal or lower rank. Writing a one to bit i of the in-service register (address 3) clears bit i.
- R11: Configuration register (address 0) resets to zero. Its layout: [1:0] slot a, [3:2] slot b, [5:4] slot c, [7:6] slot d, [12:8] promote, [15:13] level, [16] enable, [17] spread. Bits 31:18 read as zero. All reads return data one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | NSRC | Request pulses, one per source |
| bus_addr_i | input | AW | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| iack_i | input | 1 | Interrupt acknowledge from the core |
| vec_o | output | VEC_W | Latched vector |
| irq_o | output | 2**LVL_W | One-hot request toward the core |

## Verification
The bench builds the block with NSRC=12 and GAP=2. With these values, spread mode puts slots at ranks 0, 3, 6 and 9, and nine generic sources fill the gaps and the tail. A case can therefore be set up in which a generic source outranks a mapped serial channel in spread mode but loses to it in grouped mode. A promote value of 31 lies beyond the source count, so it works as the "no promotion" setting. The twelve sources also leave room to place masked, blocked and unmapped requests side by side.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int N_SLOT     = 4;
  localparam int N_SLOT_SRC = 3;
  localparam int CFG_W      = 18;

  typedef struct packed {
    logic       spread;
    logic       en;
    logic [2:0] lvl;
    logic [4:0] prom;
    logic [1:0] sel_d;
    logic [1:0] sel_c;
    logic [1:0] sel_b;
    logic [1:0] sel_a;
  } pic_cfg_t;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_PEND = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_ISR  = 3'd3;
  localparam logic [2:0] A_VEC  = 3'd4;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output pic_cfg_t      cfg_o
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_o <= '0;
    else if (wr_i) cfg_o <= pic_cfg_t'(wdata_i[CFG_W-1:0]);
  end
endmodule

// File: rtl/pic_rank.sv
module pic_rank
  import pic_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int GAP  = 3,
  parameter int RW   = 5,
  localparam int KW  = RW + 1
) (
  input  pic_cfg_t        cfg_i,
  output logic [KW-1:0]   key_o    [NSRC],
  output logic [NSRC-1:0] mapped_o
);
  logic [1:0] sel [N_SLOT];
  assign sel[0] = cfg_i.sel_a;
  assign sel[1] = cfg_i.sel_b;
  assign sel[2] = cfg_i.sel_c;
  assign sel[3] = cfg_i.sel_d;

  int   r;
  int   k;
  int   grp;
  logic m;

  always_comb begin
    r = 0; k = 0; grp = 0; m = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      r = 0;
      if (i < N_SLOT_SRC) begin
        m = 1'b0;
        // scan from the lowest slot up so the highest-priority slot wins
        for (int s = N_SLOT - 1; s >= 0; s--) begin
          if (sel[s] == 2'(i)) begin
            m = 1'b1;
            r = cfg_i.spread ? s * (GAP + 1) : s;
          end
        end
      end else begin
        m   = 1'b1;
        k   = i - N_SLOT_SRC;
        grp = (k / GAP > N_SLOT - 1) ? N_SLOT - 1 : k / GAP;
        r   = cfg_i.spread ? k + 1 + grp : N_SLOT + k;
      end
      mapped_o[i] = m;
      key_o[i]    = {(cfg_i.prom != 5'(i)), RW'(r)};
    end
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int NSRC = 16,
  parameter int KW   = 6,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] elig_i,
  input  logic [NSRC-1:0] isr_i,
  input  logic [KW-1:0]   key_i [NSRC],
  output logic            win_valid_o,
  output logic [IW-1:0]   win_idx_o
);
  logic          found;
  logic          isr_any;
  logic [KW-1:0] best;
  logic [KW-1:0] isr_key;

  always_comb begin
    found = 1'b0; isr_any = 1'b0;
    best = '1; isr_key = '1; win_idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig_i[i] && (!found || key_i[i] < best)) begin
        found = 1'b1; best = key_i[i]; win_idx_o = IW'(i);
      end
      if (isr_i[i] && (!isr_any || key_i[i] < isr_key)) begin
        isr_any = 1'b1; isr_key = key_i[i];
      end
    end
    win_valid_o = found && (!isr_any || best < isr_key);
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int GAP   = 3,
  parameter int VEC_W = 5,
  parameter int LVL_W = 3,
  parameter int AW    = 3,
  parameter int DW    = 32,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_req_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             iack_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [NLVL-1:0]  irq_o
);
  localparam int IW   = $clog2(NSRC);
  localparam int RMAX = (NSRC > 3 * (GAP + 1)) ? NSRC : 3 * (GAP + 1);
  localparam int RW   = $clog2(RMAX + 1);
  localparam int KW   = RW + 1;
  localparam logic [VEC_W-1:0] ERR_VEC = '1;

  pic_cfg_t         cfg;
  logic [NSRC-1:0]  pend_r, mask_r, isr_r, mapped, elig;
  logic [KW-1:0]    key [NSRC];
  logic             win_valid;
  logic [IW-1:0]    win_idx;
  logic [VEC_W-1:0] vec_r;
  logic [NLVL-1:0]  irq_r;
  logic [NSRC-1:0]  pend_w1c, isr_w1c, ack_hit;

  pic_cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_i(bus_wr_i && bus_addr_i == AW'(A_CFG)),
    .wdata_i(bus_wdata_i), .cfg_o(cfg)
  );

  pic_rank #(.NSRC(NSRC), .GAP(GAP), .RW(RW)) u_rank (
    .cfg_i(cfg), .key_o(key), .mapped_o(mapped)
  );

  assign elig = pend_r & mask_r & mapped;

  pic_arb #(.NSRC(NSRC), .KW(KW)) u_arb (
    .elig_i(elig), .isr_i(isr_r), .key_i(key),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  assign pend_w1c = (bus_wr_i && bus_addr_i == AW'(A_PEND)) ? bus_wdata_i[NSRC-1:0] : '0;
  assign isr_w1c  = (bus_wr_i && bus_addr_i == AW'(A_ISR))  ? bus_wdata_i[NSRC-1:0] : '0;
  assign ack_hit  = (iack_i && win_valid) ? (NSRC'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_r <= '0;
      mask_r <= '0;
      isr_r  <= '0;
      vec_r  <= '0;
      irq_r  <= '0;
    end else begin
      pend_r <= (pend_r & ~pend_w1c & ~ack_hit) | src_req_i;
      isr_r  <= (isr_r & ~isr_w1c) | ack_hit;
      if (bus_wr_i && bus_addr_i == AW'(A_MASK)) mask_r <= bus_wdata_i[NSRC-1:0];
      if (iack_i) vec_r <= win_valid ? VEC_W'(win_idx) : ERR_VEC;
      irq_r <= (cfg.en && win_valid) ? (NLVL'(1) << cfg.lvl) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else begin
      case (bus_addr_i)
        AW'(A_CFG):  bus_rdata_o <= DW'(cfg);
        AW'(A_PEND): bus_rdata_o <= DW'(pend_r);
        AW'(A_MASK): bus_rdata_o <= DW'(mask_r);
        AW'(A_ISR):  bus_rdata_o <= DW'(isr_r);
        AW'(A_VEC):  bus_rdata_o <= DW'(vec_r);
        default:     bus_rdata_o <= '0;
      endcase
    end
  end

  assign vec_o = vec_r;
  assign irq_o = irq_r;

  assert_pend_set_R1: assert property (@(posedge clk) disable iff (rst)
    (|src_req_i) |=> ((pend_r & $past(src_req_i)) == $past(src_req_i)));
  assert_win_unmasked_R2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend_r[win_idx] && mask_r[win_idx]));
  assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_r));
  assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> (irq_r == '0));
  assert_isr_set_R8: assert property (@(posedge clk) disable iff (rst)
    (iack_i && win_valid) |=> isr_r[$past(win_idx)]);
  assert_err_vec_R9: assert property (@(posedge clk) disable iff (rst)
    (iack_i && !win_valid) |=> (vec_r == ERR_VEC));
  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr_i) == AW'(A_CFG)) |-> (bus_rdata_o[DW-1:CFG_W] == '0));
endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  localparam int NSRC = 12;
  localparam int GAP  = 2;
  localparam int ERR  = 31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] src_req = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        iack = 1'b0;
  logic [4:0]  vec;
  logic [7:0]  irq;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  logic ack_d = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_intc #(.NSRC(NSRC), .GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .src_req_i(src_req), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .iack_i(iack), .vec_o(vec), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk); src_req = m;
    @(negedge clk); src_req = '0;
  endtask

  // driver: pushes the expected vector, monitor compares after the edge
  task automatic ack(input int exp, input string tag);
    @(negedge clk); exp_q.push_back(exp); tag_q.push_back(tag); iack = 1'b1;
    @(negedge clk); iack = 1'b0;
  endtask

  task automatic clr_all();
    wreg(3'd3, 32'hFFF);
    wreg(3'd1, 32'hFFF);
  endtask

  function automatic logic [31:0] cfgv(input int sa, sb, sc, sd, prom, lvl, en, sp);
    return 32'(sp << 17 | en << 16 | lvl << 13 | prom << 8 | sd << 6 | sc << 4 | sb << 2 | sa);
  endfunction

  always @(posedge clk) ack_d <= iack;

  always @(negedge clk) begin
    if (ack_d) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), 32'(vec), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(1);
    chk("R7 reset irq", 32'(irq), 0);
    chk("R8 reset vec", 32'(vec), 0);
    rchk(3'd0, 0, "R11 cfg reset");
    rchk(3'd2, 0, "R2 mask reset");

    ack(ERR, "R9 ack idle");
    wreg(3'd2, 32'hFFF);
    wreg(3'd0, cfgv(0, 1, 2, 3, 31, 5, 1, 0));

    pulse(12'h024);
    cyc(2);
    chk("R7 level 5", 32'(irq), 32'h20);
    rchk(3'd1, 32'h24, "R1 pending set");
    ack(2, "R4 R5 grouped slot beats generic");
    cyc(2);
    chk("R10 blocked by in-service", 32'(irq), 0);
    rchk(3'd1, 32'h20, "R8 ack clears pending");
    wreg(3'd3, 32'h4);
    cyc(2);
    chk("R10 released after clear", 32'(irq), 32'h20);
    ack(5, "R4 generic vector");
    rchk(3'd4, 5, "R8 vector register");
    clr_all();

    wreg(3'd0, cfgv(2, 0, 3, 3, 31, 5, 1, 0));
    pulse(12'h005);
    ack(2, "R3 remap serial3 to slot a");
    wreg(3'd3, 32'hFFF);
    ack(0, "R4 usb vector fixed");
    clr_all();

    wreg(3'd0, cfgv(1, 2, 3, 3, 31, 5, 1, 0));
    pulse(12'h001);
    cyc(2);
    chk("R3 unmapped usb silent", 32'(irq), 0);
    ack(ERR, "R3 R9 unmapped usb");
    clr_all();

    wreg(3'd0, cfgv(3, 1, 0, 3, 31, 5, 1, 1));
    pulse(12'h012);
    ack(4, "R5 spread generic beats slot b");
    wreg(3'd3, 32'hFFF);
    ack(1, "R5 spread slot b next");
    clr_all();
    pulse(12'h081);
    ack(0, "R5 spread slot c beats source 7");
    clr_all();
    wreg(3'd0, cfgv(3, 1, 0, 3, 31, 5, 1, 0));
    pulse(12'h012);
    ack(1, "R5 grouped slot b beats generic");
    clr_all();

    wreg(3'd0, cfgv(0, 1, 2, 3, 9, 5, 1, 0));
    pulse(12'h201);
    ack(9, "R6 promoted source");
    clr_all();

    wreg(3'd0, cfgv(0, 1, 2, 3, 31, 5, 1, 0));
    wreg(3'd2, 32'hFBF);
    pulse(12'h040);
    cyc(2);
    chk("R2 masked no irq", 32'(irq), 0);
    rchk(3'd1, 32'h40, "R2 masked stays pending");
    ack(ERR, "R9 masked ack");
    wreg(3'd2, 32'hFFF);
    cyc(2);
    chk("R2 unmask raises irq", 32'(irq), 32'h20);
    ack(6, "R2 unmasked ack");
    clr_all();

    pulse(12'h008);
    cyc(2);
    chk("R7 irq before late mask", 32'(irq), 32'h20);
    wreg(3'd2, 32'hFF7);
    ack(ERR, "R9 masked after request");
    wreg(3'd2, 32'hFFF);
    clr_all();

    wreg(3'd0, cfgv(0, 1, 2, 3, 31, 5, 0, 0));
    pulse(12'h010);
    cyc(2);
    chk("R7 disabled", 32'(irq), 0);
    wreg(3'd0, cfgv(0, 1, 2, 3, 31, 0, 1, 0));
    cyc(2);
    chk("R7 level 0", 32'(irq), 32'h01);
    wreg(3'd0, cfgv(0, 1, 2, 3, 31, 7, 1, 0));
    cyc(2);
    chk("R7 level 7", 32'(irq), 32'h80);
    clr_all();

    wreg(3'd0, 32'hFFFF_FFFF);
    rchk(3'd0, 32'h0003_FFFF, "R11 reserved read zero");

    @(negedge clk); addr = 3'd1; wdata = 32'h100; wr = 1'b1; src_req = 12'h100;
    @(negedge clk); wr = 1'b0; src_req = '0;
    rchk(3'd1, 32'h100, "R1 set wins over clear");
    wreg(3'd1, 32'h100);
    rchk(3'd1, 0, "R1 write one clears");

    cyc(2);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule